// File: doc/BRIEF.md
# Serial Bit Counter and Status Unit

This block counts the bits of a universal serial port that can run as a three-wire or a two-wire link. A small counter advances once per clock event. The event source is set in a control register: a software strobe, a timer compare-match pulse, or a rising or falling edge of the external serial clock. When an external source is chosen, a stored software-clock bit hands the counter over to a toggle strobe written by the CPU.

Around the counter the block keeps three sticky flags: start seen, counter overflow and stop seen. It also shows a live collision bit. It raises two interrupt requests, each gated by its own enable and a global enable. In two-wire mode it asks for the serial clock to be held low while the start or overflow flag is pending. The shift register, pin drivers and start/stop detectors sit outside; their results come in as inputs. Software sees a control register and a status register over a simple single-cycle write, combinational read port.

Top module: `sic_counter_unit`

## Requirements
- R1: After reset both registers read 0x00 and irq_start, irq_ovf and scl_hold are low.
- R2: The control register (reg_sel=0) stores bit 7 start-interrupt enable, bit 6 overflow-interrupt enable, bits 5:4 wire mode and bits 3:2 clock source. Bit 1 (software clock) and bit 0 (toggle strobe) always read back as zero.
- R3: The status register (reg_sel=1) shows the counter in bits 3:0. A status write loads the counter from bits 3:0, and this load wins over an increment in the same cycle.
- R4: With clock source 00, a control write that has bit 1 set adds one to the counter. Nothing else moves it.
- R5: With clock source 01, the counter adds one for every clock cycle in which tmr_match is high.
- R6: With clock source 10 the counter counts rising edges of ext_clk, and with 11 it counts falling edges. This holds in every wire mode, including mode 00. With no synchronizer stages, the count appears one cycle after the level change.
- R7: With clock source 1x and the software clock bit stored as one, ext_clk edges are ignored. Each control write with bits 1 and 0 both set adds one.
- R8: A wrap from the all-ones value to zero sets the overflow flag (status bit 6). The flag is cleared by a status write with bit 6 set or by a buf_rd pulse. A set in the same cycle as a clear wins.
- R9: In two-wire mode (wire-mode bit 5 = 1), a start_det pulse sets status bit 7. Only a status write with bit 7 set clears it; buf_rd leaves it alone. Outside two-wire mode, start_det is ignored.
- R10: In two-wire mode a stop_det pulse sets status bit 5, which a status write with bit 5 set clears. It never drives either interrupt. Outside two-wire mode, stop_det is ignored.
- R11: Status bit 4 is high when shreg_msb differs from sda_in in two-wire mode, and is low otherwise.
- R12: irq_start is high when the start flag, control bit 7 and gie are all set. irq_ovf is high when the overflow flag, control bit 6 and gie are all set.
- R13: scl_hold is high in two-wire mode while the start or overflow flag is set, and is low outside two-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| buf_rd | input | 1 | Pulse when software reads the data buffer |
| gie | input | 1 | Global interrupt enable |
| ext_clk | input | 1 | External serial clock level |
| tmr_match | input | 1 | Timer compare-match pulse |
| start_det | input | 1 | Start condition detected pulse |
| stop_det | input | 1 | Stop condition detected pulse |
| shreg_msb | input | 1 | Top bit of the shift register |
| sda_in | input | 1 | Sampled data pin level |
| irq_start | output | 1 | Start interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| scl_hold | output | 1 | Request to hold the serial clock low |

## Verification
The bench builds the block with a 4-bit counter and zero synchronizer stages. The full status byte layout is therefore visible, and an ext_clk level change lands in the counter exactly one cycle later. That exact timing lets the vector table step through every clock source with cycle-exact expectations. With a 4-bit counter, reaching a wrap takes only a few strobes, so the overflow set-versus-clear race and the load-versus-increment race can each be staged in a single cycle.

// File: rtl/sic_pkg.sv
package sic_pkg;

   typedef enum logic [1:0] {
      SRC_SOFT     = 2'b00,
      SRC_TIMER    = 2'b01,
      SRC_EXT_RISE = 2'b10,
      SRC_EXT_FALL = 2'b11
   } clk_src_e;

   typedef struct packed {
      logic       start_ie;
      logic       ovf_ie;
      logic [1:0] wmode;
      clk_src_e   src;
      logic       soft_clk;
   } ctrl_t;

   localparam logic SEL_CTRL = 1'b0;
   localparam logic SEL_STAT = 1'b1;

   localparam int FLG_START = 0;
   localparam int FLG_OVF   = 1;
   localparam int FLG_STOP  = 2;
   localparam int NFLAGS    = 3;

endpackage

// File: rtl/sic_flag.sv
module sic_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   // R8: an event arriving with a clear is not lost
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
   // R9: a clear without a set empties the flag
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q);

endmodule

// File: rtl/sic_bit_counter.sv
module sic_bit_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   assign wrap = inc && !load && (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= ld_val;
      else if (inc)  cnt <= cnt + W'(1);
   end

   // R3: a software load beats a same-cycle increment
   assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(ld_val)));
   // R5: each clock event moves the count by exactly one
   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> (cnt == $past(cnt) + W'(1)));
   // R8: the top value rolls over to zero
   assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && cnt == CNT_MAX) |=> (cnt == '0));

endmodule

// File: rtl/sic_clk_select.sv
module sic_clk_select
   import sic_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ext_clk,
   input  logic  tmr_match,
   input  ctrl_t cfg,
   input  logic  strobe_clk,
   input  logic  strobe_tog,
   output logic  tick
);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("sic_clk_select: SYNC_STAGES must lie in 0..3");
   end

   logic ext_s;
   logic ext_prev;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign ext_s = ext_clk;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= (chain << 1) | SYNC_STAGES'(ext_clk);
      end
      assign ext_s = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_prev <= 1'b0;
      else        ext_prev <= ext_s;
   end

   logic rise, fall;
   assign rise = ext_s && !ext_prev;
   assign fall = !ext_s && ext_prev;

   always_comb begin
      unique case (cfg.src)
         SRC_SOFT:  tick = strobe_clk;
         SRC_TIMER: tick = tmr_match;
         default:   tick = cfg.soft_clk ? (strobe_clk && strobe_tog)
                                        : (cfg.src == SRC_EXT_FALL ? fall : rise);
      endcase
   end

endmodule

// File: rtl/sic_counter_unit.sv
module sic_counter_unit
   import sic_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_sel,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       buf_rd,
   input  logic       gie,
   input  logic       ext_clk,
   input  logic       tmr_match,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       shreg_msb,
   input  logic       sda_in,
   output logic       irq_start,
   output logic       irq_ovf,
   output logic       scl_hold
);

   if (CNT_W < 2 || CNT_W > 4) begin : g_bad_cntw
      $error("sic_counter_unit: CNT_W must lie in 2..4");
   end

   logic ctrl_wr, stat_wr;
   assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
   assign stat_wr = reg_wr && (reg_sel == SEL_STAT);

   // control register; strobes act on the write, soft_clk is kept as mode
   ctrl_t ctrl_q, ctrl_new, ctrl_eff;
   assign ctrl_new = '{start_ie: reg_wdata[7], ovf_ie: reg_wdata[6],
                       wmode: reg_wdata[5:4], src: clk_src_e'(reg_wdata[3:2]),
                       soft_clk: reg_wdata[1]};
   assign ctrl_eff = ctrl_wr ? ctrl_new : ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= ctrl_new;
   end

   logic two_wire;
   assign two_wire = ctrl_q.wmode[1];

   logic tick;
   sic_clk_select #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_clk    (ext_clk),
      .tmr_match  (tmr_match),
      .cfg        (ctrl_eff),
      .strobe_clk (ctrl_wr && reg_wdata[1]),
      .strobe_tog (ctrl_wr && reg_wdata[0]),
      .tick       (tick)
   );

   logic [CNT_W-1:0] cnt_q;
   logic             wrap;
   sic_bit_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (tick),
      .load   (stat_wr),
      .ld_val (reg_wdata[CNT_W-1:0]),
      .cnt    (cnt_q),
      .wrap   (wrap)
   );

   logic [NFLAGS-1:0] flag_set, flag_clr, flag_q;
   assign flag_set[FLG_START] = start_det && two_wire;
   assign flag_clr[FLG_START] = stat_wr && reg_wdata[7];
   assign flag_set[FLG_OVF]   = wrap;
   assign flag_clr[FLG_OVF]   = (stat_wr && reg_wdata[6]) || buf_rd;
   assign flag_set[FLG_STOP]  = stop_det && two_wire;
   assign flag_clr[FLG_STOP]  = stat_wr && reg_wdata[5];

   for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
      sic_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (flag_set[i]),
         .clr   (flag_clr[i]),
         .q     (flag_q[i])
      );
   end

   logic collide;
   assign collide = two_wire && (shreg_msb != sda_in);

   logic [3:0] cnt_view;
   assign cnt_view = 4'(cnt_q);

   always_comb begin
      if (reg_sel == SEL_CTRL)
         reg_rdata = {ctrl_q.start_ie, ctrl_q.ovf_ie, ctrl_q.wmode, ctrl_q.src, 2'b00};
      else
         reg_rdata = {flag_q[FLG_START], flag_q[FLG_OVF], flag_q[FLG_STOP], collide, cnt_view};
   end

   assign irq_start = flag_q[FLG_START] && ctrl_q.start_ie && gie;
   assign irq_ovf   = flag_q[FLG_OVF] && ctrl_q.ovf_ie && gie;
   assign scl_hold  = two_wire && (flag_q[FLG_START] || flag_q[FLG_OVF]);

   // R8: the overflow flag only rises together with a rollover to zero
   assert_ovf_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[FLG_OVF]) |-> (cnt_q == '0));
   // R4: in software mode with no register write the count stays put
   assert_soft_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && ctrl_q.src == SRC_SOFT) |=> $stable(cnt_q));

endmodule

// File: tb/sim_sic_counter_unit.sv
module sim_sic_counter_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       buf_rd = 1'b0, gie = 1'b0, ext_clk = 1'b0, tmr_match = 1'b0;
   logic       start_det = 1'b0, stop_det = 1'b0, shreg_msb = 1'b0, sda_in = 1'b0;
   logic       irq_start, irq_ovf, scl_hold;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   sic_counter_unit #(.CNT_W(4), .SYNC_STAGES(0)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_rd(buf_rd), .gie(gie),
      .ext_clk(ext_clk), .tmr_match(tmr_match), .start_det(start_det),
      .stop_det(stop_det), .shreg_msb(shreg_msb), .sda_in(sda_in),
      .irq_start(irq_start), .irq_ovf(irq_ovf), .scl_hold(scl_hold)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, input logic [7:0] exp, input string req);
      reg_sel = sel;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic tmr(input int n);
      @(negedge clk);
      tmr_match = 1'b1;
      repeat (n) @(negedge clk);
      tmr_match = 1'b0;
   endtask

   // 0 buf_rd, 1 start_det, 2 stop_det
   task automatic pulse_in(input int which);
      @(negedge clk);
      case (which)
         0: buf_rd = 1'b1;
         1: start_det = 1'b1;
         default: stop_det = 1'b1;
      endcase
      @(negedge clk);
      buf_rd = 1'b0; start_det = 1'b0; stop_det = 1'b0;
   endtask

   // vector: {kind, sel, data, expected, requirement number}
   // kind 0 write, 1 read and compare, 2 timer pulses (data = count), 3 ext_clk level
   localparam int NV = 33;
   localparam logic [23:0] VEC [NV] = '{
      {2'd1, 2'd0, 8'h00, 8'h00, 4'd1},   // R1 control after reset
      {2'd1, 2'd1, 8'h00, 8'h00, 4'd1},   // R1 status after reset
      {2'd0, 2'd0, 8'hD8, 8'h00, 4'd2},
      {2'd1, 2'd0, 8'h00, 8'hD8, 4'd2},   // R2 fields stored
      {2'd0, 2'd0, 8'h00, 8'h00, 4'd2},
      {2'd1, 2'd0, 8'h00, 8'h00, 4'd2},
      {2'd0, 2'd1, 8'h05, 8'h00, 4'd3},
      {2'd1, 2'd1, 8'h00, 8'h05, 4'd3},   // R3 counter load
      {2'd0, 2'd0, 8'h02, 8'h00, 4'd4},
      {2'd1, 2'd0, 8'h00, 8'h00, 4'd2},   // R2 strobe reads zero
      {2'd1, 2'd1, 8'h00, 8'h06, 4'd4},   // R4 software strobe
      {2'd0, 2'd0, 8'h04, 8'h00, 4'd5},
      {2'd2, 2'd0, 8'h03, 8'h00, 4'd5},
      {2'd1, 2'd1, 8'h00, 8'h09, 4'd5},   // R5 timer source
      {2'd0, 2'd0, 8'h08, 8'h00, 4'd6},
      {2'd3, 2'd0, 8'h01, 8'h00, 4'd6},
      {2'd3, 2'd0, 8'h00, 8'h00, 4'd6},
      {2'd3, 2'd0, 8'h01, 8'h00, 4'd6},
      {2'd1, 2'd1, 8'h00, 8'h0B, 4'd6},   // R6 rising edges, wire mode 00
      {2'd0, 2'd0, 8'h0C, 8'h00, 4'd6},
      {2'd3, 2'd0, 8'h00, 8'h00, 4'd6},
      {2'd1, 2'd1, 8'h00, 8'h0C, 4'd6},   // R6 falling edge
      {2'd0, 2'd0, 8'h0A, 8'h00, 4'd7},
      {2'd3, 2'd0, 8'h01, 8'h00, 4'd7},
      {2'd3, 2'd0, 8'h00, 8'h00, 4'd7},
      {2'd1, 2'd1, 8'h00, 8'h0C, 4'd7},   // R7 edges ignored
      {2'd0, 2'd0, 8'h0B, 8'h00, 4'd7},
      {2'd1, 2'd1, 8'h00, 8'h0D, 4'd7},   // R7 toggle counts
      {2'd0, 2'd0, 8'h0B, 8'h00, 4'd7},
      {2'd0, 2'd0, 8'h0B, 8'h00, 4'd7},
      {2'd1, 2'd1, 8'h00, 8'h0F, 4'd7},
      {2'd0, 2'd0, 8'h0B, 8'h00, 4'd8},
      {2'd1, 2'd1, 8'h00, 8'h40, 4'd8}    // R8 wrap sets overflow
   };

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 irq_start", {7'd0, irq_start}, 8'h00);
      chk("R1 irq_ovf", {7'd0, irq_ovf}, 8'h00);
      chk("R1 scl_hold", {7'd0, scl_hold}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [23:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d vec%0d", v[3:0], i);
         case (v[23:22])
            2'd0: wr(v[20], v[19:12]);
            2'd1: rd(v[20], v[11:4], tag);
            2'd2: tmr(int'(v[19:12]));
            default: begin
               @(negedge clk); ext_clk = v[12]; @(negedge clk);
            end
         endcase
      end

      // R13: overflow pending outside two-wire mode does not hold the clock
      #1 chk("R13 no hold in mode 00", {7'd0, scl_hold}, 8'h00);
      // R8: buffer read clears overflow
      pulse_in(0);
      rd(1'b1, 8'h00, "R8 buf_rd clear");
      // R8: write-one clear
      wr(1'b0, 8'h04);
      wr(1'b1, 8'h0F);
      tmr(1);
      rd(1'b1, 8'h40, "R8 wrap via timer");
      wr(1'b1, 8'h40);
      rd(1'b1, 8'h00, "R8 write-one clear");
      // R8: set wins over same-cycle clear
      wr(1'b1, 8'h0F);
      @(negedge clk); tmr_match = 1'b1; buf_rd = 1'b1;
      @(negedge clk); tmr_match = 1'b0; buf_rd = 1'b0;
      rd(1'b1, 8'h40, "R8 set wins");
      pulse_in(0);
      // R3: load beats increment
      wr(1'b1, 8'h03);
      @(negedge clk); tmr_match = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h09; reg_wr = 1'b1;
      @(negedge clk); tmr_match = 1'b0; reg_wr = 1'b0;
      rd(1'b1, 8'h09, "R3 load priority");
      wr(1'b1, 8'h00);

      // R9 R12 R13: start flag in two-wire mode
      wr(1'b0, 8'hE4);
      pulse_in(1);
      rd(1'b1, 8'h80, "R9 start set");
      chk("R12 irq_start gated by gie", {7'd0, irq_start}, 8'h00);
      chk("R13 hold on start", {7'd0, scl_hold}, 8'h01);
      gie = 1'b1;
      #1 chk("R12 irq_start", {7'd0, irq_start}, 8'h01);
      chk("R12 irq_ovf idle", {7'd0, irq_ovf}, 8'h00);
      pulse_in(0);
      rd(1'b1, 8'h80, "R9 buf_rd keeps start");
      wr(1'b1, 8'h80);
      rd(1'b1, 8'h00, "R9 start cleared");
      chk("R13 hold released", {7'd0, scl_hold}, 8'h00);
      chk("R12 irq_start released", {7'd0, irq_start}, 8'h00);

      // R10: stop flag
      pulse_in(2);
      rd(1'b1, 8'h20, "R10 stop set");
      chk("R10 no irq_start", {7'd0, irq_start}, 8'h00);
      chk("R10 no irq_ovf", {7'd0, irq_ovf}, 8'h00);
      wr(1'b1, 8'h20);
      rd(1'b1, 8'h00, "R10 stop cleared");

      // R11: collision
      @(negedge clk); shreg_msb = 1'b1; sda_in = 1'b0;
      rd(1'b1, 8'h10, "R11 collision");
      sda_in = 1'b1;
      rd(1'b1, 8'h00, "R11 match");
      wr(1'b0, 8'h04);
      sda_in = 1'b0;
      rd(1'b1, 8'h00, "R11 off outside two-wire");
      shreg_msb = 1'b0;

      // R9 R10: detectors ignored outside two-wire mode
      pulse_in(1);
      rd(1'b1, 8'h00, "R9 start ignored mode 00");
      pulse_in(2);
      rd(1'b1, 8'h00, "R10 stop ignored mode 00");

      // R12 R13: overflow interrupt and hold
      wr(1'b0, 8'hE4);
      wr(1'b1, 8'h0F);
      tmr(1);
      rd(1'b1, 8'h40, "R8 overflow two-wire");
      chk("R12 irq_ovf", {7'd0, irq_ovf}, 8'h01);
      chk("R13 hold on overflow", {7'd0, scl_hold}, 8'h01);
      gie = 1'b0;
      #1 chk("R12 irq_ovf gated by gie", {7'd0, irq_ovf}, 8'h00);
      pulse_in(0);
      #1 chk("R13 hold released by buf_rd", {7'd0, scl_hold}, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule